// File: doc/BRIEF.md
# Power-Aware Programmable Watchdog Timer

This block is the watchdog of a small 8-bit microcontroller. It counts machine cycles, which are marked by a one-clock enable. If software fails to service it before the selected timeout, it drives a reset pulse to the chip. A 3-bit select field picks one of eight timeouts. Each timeout is one less than a power of two machine cycles, from 2^BASE_EXP−1 up to 2^(BASE_EXP+7)−1. With the default BASE_EXP of 14 this spans 2^14−1 to 2^21−1.

The watchdog is off after reset. Software turns it on, and later services it, by writing a two-byte key to a service register. The counter is aware of the low-power modes:
- In idle it keeps counting.
- In power-down it holds its value.
- When power-down ends through an external interrupt, it stays halted until the active-low interrupt pin returns high. A wake-up line held low for a long time therefore cannot cause a watchdog reset.

A hardware reset during power-down returns everything to the reset state.

Top module: `pm_watchdog`

## Requirements
- R1: After `rst_n` is released, `wdt_rst_o` is low, the select register reads 0, and the watchdog is disabled: no reset pulse occurs, however long the clock runs, until a valid service pair has been written.
- R2: The select register is at address 0xA7. Bits 2:0 hold the select value S and read back as written. Bits 7:3 always read 0, and writes to them have no effect.
- R3: After a valid service pair, `wdt_rst_o` rises after exactly 2^(BASE_EXP+S)−1 machine-cycle ticks. A tick is a rising clock edge with `mc_en_i` high that is not frozen by power-down. Edges with `mc_en_i` low do not count.
- R4: On expiry, `wdt_rst_o` stays high for exactly PULSE_LEN clock cycles (default 96). The count is cleared and the watchdog is disabled until the next valid service pair.
- R5: The service register is at address 0xA6. Writing 0x1E and then 0xE1 to it on consecutive writes forms a valid pair, which enables the watchdog and clears the count. A lone 0xE1, or 0x1E followed by any other value and then 0xE1, has no effect.
- R6: Every valid service pair written while the watchdog runs restarts the timeout from zero.
- R7: The idle input `idle_i` has no effect. The count keeps advancing in idle, and expiry occurs at the same tick as without idle.
- R8: While `pdown_i` is high, the count holds its value. After power-down ends with `int_n_i` high, counting resumes from the held value.
- R9: When `pdown_i` falls while `int_n_i` is low, counting stays halted on every edge from that exit up to and including the first edge at which `int_n_i` is sampled high.
- R10: Asserting `rst_n` during power-down restores the R1 state: select value 0, watchdog disabled, no pending reset pulse.
- R11: A write to the select field while the watchdog runs leaves the current timeout unchanged. The new value is used from the next valid service pair on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| mc_en_i | input | 1 | One-clock machine-cycle enable |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address for write and read |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i` (combinational) |
| idle_i | input | 1 | Core is in idle mode |
| pdown_i | input | 1 | Core is in power-down mode |
| int_n_i | input | 1 | External interrupt pin level, active low |
| wdt_rst_o | output | 1 | Watchdog reset pulse to the chip |

## Verification
The timeout is measured to the exact edge for two select values, with the enable high on every clock and with it high on one clock in three. These runs tell apart an off-by-one terminal count, a wrong exponent, and counting of plain clocks instead of machine cycles. Power-down is exercised in three ways: a freeze exited with the pin high, an exit with the pin held low for many cycles, and a hardware reset taken during power-down. The expected edge counts differ by the frozen edges, so a missing freeze or a hold released one edge early shows up as a shifted reset edge. Key sequences, select changes mid-count and idle runs are checked against the same edge arithmetic.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
    localparam int unsigned DW    = 8;
    localparam int unsigned SEL_W = 3;

    typedef logic [DW-1:0]    byte_t;
    typedef logic [SEL_W-1:0] sel_t;

    localparam byte_t SEL_ADDR_DEF = 8'hA7;
    localparam byte_t SVC_ADDR_DEF = 8'hA6;
    localparam byte_t KEY_ARM      = 8'h1E;
    localparam byte_t KEY_FIRE     = 8'hE1;
endpackage

// File: rtl/pmw_regs.sv
module pmw_regs
    import pmw_pkg::*;
#(
    parameter byte_t SEL_ADDR = SEL_ADDR_DEF,
    parameter byte_t SVC_ADDR = SVC_ADDR_DEF
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en_i,
    input  byte_t addr_i,
    input  byte_t wdata_i,
    output byte_t rdata_o,
    output sel_t  sel_o,
    output logic  svc_o
);
    typedef struct packed {
        sel_t sel;
        logic armed;
    } regs_t;

    regs_t q, d;
    logic  svc;

    always_comb begin
        d   = q;
        svc = 1'b0;
        if (wr_en_i) begin
            if (addr_i == SEL_ADDR) begin
                d.sel = wdata_i[SEL_W-1:0];
            end else if (addr_i == SVC_ADDR) begin
                if (wdata_i == KEY_ARM) begin
                    d.armed = 1'b1;
                end else if (q.armed && (wdata_i == KEY_FIRE)) begin
                    svc     = 1'b1;
                    d.armed = 1'b0;
                end else begin
                    d.armed = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == SEL_ADDR) rdata_o[SEL_W-1:0] = q.sel;
    end

    assign sel_o = q.sel;
    assign svc_o = svc;
endmodule

// File: rtl/pmw_gate.sv
module pmw_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pdown_i,
    input  logic int_n_i,
    output logic frozen_o
);
    typedef struct packed {
        logic pd_prev;
        logic hold;
    } gate_t;

    gate_t q, d;
    logic  wake_low;

    always_comb begin
        d          = q;
        wake_low   = q.pd_prev && !pdown_i && !int_n_i;
        d.pd_prev  = pdown_i;
        if (wake_low)     d.hold = 1'b1;
        else if (int_n_i) d.hold = 1'b0;
        frozen_o   = pdown_i || q.hold || wake_low;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pmw_core.sv
module pmw_core
    import pmw_pkg::*;
#(
    parameter int unsigned BASE_EXP  = 14,
    parameter int unsigned PULSE_LEN = 96,
    localparam int unsigned CW = BASE_EXP + (1 << SEL_W),
    localparam int unsigned PW = $clog2(PULSE_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mc_en_i,
    input  logic          frozen_i,
    input  logic          svc_i,
    input  sel_t          sel_i,
    output logic [CW-1:0] cnt_o,
    output logic          rst_o
);
    typedef struct packed {
        logic          en;
        sel_t          sel_act;
        logic [CW-1:0] cnt;
        logic          pulse;
        logic [PW-1:0] pcnt;
    } core_t;

    localparam logic [CW-1:0] ONE = CW'(1);

    core_t         q, d;
    logic          tick;
    logic [CW-1:0] last_val;

    always_comb begin
        d        = q;
        tick     = q.en && mc_en_i && !frozen_i;
        last_val = (ONE << (BASE_EXP + int'(q.sel_act))) - CW'(2);
        if (tick) begin
            if (q.cnt == last_val) begin
                d.cnt   = '0;
                d.en    = 1'b0;
                d.pulse = 1'b1;
                d.pcnt  = PW'(PULSE_LEN - 1);
            end else begin
                d.cnt = q.cnt + ONE;
            end
        end
        if (q.pulse) begin
            if (q.pcnt == '0) d.pulse = 1'b0;
            else              d.pcnt  = q.pcnt - PW'(1);
        end
        if (svc_i) begin
            d.en      = 1'b1;
            d.cnt     = '0;
            d.sel_act = sel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o = q.cnt;
    assign rst_o = q.pulse;
endmodule

// File: rtl/pm_watchdog.sv
module pm_watchdog
    import pmw_pkg::*;
#(
    parameter int unsigned BASE_EXP  = 14,
    parameter int unsigned PULSE_LEN = 96,
    parameter byte_t       SEL_ADDR  = SEL_ADDR_DEF,
    parameter byte_t       SVC_ADDR  = SVC_ADDR_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mc_en_i,
    input  logic       wr_en_i,
    input  logic [7:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    input  logic       idle_i,
    input  logic       pdown_i,
    input  logic       int_n_i,
    output logic       wdt_rst_o
);
    localparam int unsigned CW = BASE_EXP + (1 << SEL_W);

    sel_t          sel_w;
    logic          svc_w;
    logic          frozen_w;
    logic [CW-1:0] cnt_w;
    logic          unused_idle;

    // idle keeps the oscillator running, so the count is not gated by it
    assign unused_idle = idle_i;

    pmw_regs #(.SEL_ADDR(SEL_ADDR), .SVC_ADDR(SVC_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .sel_o(sel_w), .svc_o(svc_w)
    );

    pmw_gate u_gate (
        .clk(clk), .rst_n(rst_n), .pdown_i(pdown_i), .int_n_i(int_n_i),
        .frozen_o(frozen_w)
    );

    pmw_core #(.BASE_EXP(BASE_EXP), .PULSE_LEN(PULSE_LEN)) u_core (
        .clk(clk), .rst_n(rst_n), .mc_en_i(mc_en_i), .frozen_i(frozen_w),
        .svc_i(svc_w), .sel_i(sel_w), .cnt_o(cnt_w), .rst_o(wdt_rst_o)
    );
endmodule

// File: rtl/pm_watchdog_chk.sv
module pm_watchdog_chk #(
    parameter int unsigned CW        = 22,
    parameter int unsigned SEL_W     = 3,
    parameter int unsigned PULSE_LEN = 96,
    parameter logic [7:0]  SEL_ADDR  = 8'hA7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pdown_i,
    input logic          int_n_i,
    input logic [7:0]    addr_i,
    input logic [7:0]    rdata_o,
    input logic          wdt_rst_o,
    input logic          svc,
    input logic [CW-1:0] cnt
);
    logic        seen_svc;
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_svc <= 1'b0;
            hi_cnt   <= '0;
        end else begin
            if (svc) seen_svc <= 1'b1;
            hi_cnt <= wdt_rst_o ? hi_cnt + 16'd1 : 16'd0;
        end
    end

    // R1
    disabled_until_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_svc |-> !wdt_rst_o);

    // R2
    rsvd_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == SEL_ADDR) |-> ((rdata_o >> SEL_W) == 8'd0));

    // R4
    pulse_not_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> (hi_cnt < 16'(PULSE_LEN)));

    // R4
    pulse_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst_o) |-> (hi_cnt == 16'(PULSE_LEN)));

    // R6
    svc_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> (cnt == '0));

    // R8
    pdown_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pdown_i && !svc) |=> (cnt == $past(cnt)));

    // R9
    wake_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pdown_i) && !pdown_i && !int_n_i && !svc) |=> (cnt == $past(cnt)));
endmodule

bind pm_watchdog pm_watchdog_chk #(
    .CW(CW), .SEL_W(pmw_pkg::SEL_W), .PULSE_LEN(PULSE_LEN), .SEL_ADDR(SEL_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pdown_i(pdown_i), .int_n_i(int_n_i),
    .addr_i(addr_i), .rdata_o(rdata_o), .wdt_rst_o(wdt_rst_o),
    .svc(svc_w), .cnt(cnt_w)
);

// File: tb/pm_watchdog_tb.sv
`timescale 1ns/1ps
module pm_watchdog_tb;
    localparam int BASE = 4;
    localparam int PLEN = 96;
    localparam logic [7:0] A_SEL = 8'hA7;
    localparam logic [7:0] A_SVC = 8'hA6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mc_en = 1'b1, wr_en = 1'b0, idle = 1'b0, pdown = 1'b0, int_n = 1'b1;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;
    logic wrst;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    pm_watchdog #(.BASE_EXP(BASE), .PULSE_LEN(PLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .mc_en_i(mc_en), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .idle_i(idle),
        .pdown_i(pdown), .int_n_i(int_n), .wdt_rst_o(wrst)
    );

    function automatic int term(input int s);
        return (1 << (BASE + s)) - 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic service();
        wr(A_SVC, 8'h1E);
        wr(A_SVC, 8'hE1);
    endtask

    task automatic wait_rst(input int limit, output int n);
        n = 0;
        while (!wrst && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_len(output int h);
        h = 0;
        while (wrst && h < 1000) begin
            h++;
            @(negedge clk);
        end
    endtask

    task automatic run_quiet(input int cyc, input string req);
        int hits = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (wrst) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk(wrst == 1'b0, "R1", int'(wrst), 0);
        rd(A_SEL, v);
        chk(v == 8'h00, "R1", int'(v), 0);
        run_quiet(3 * term(7), "R1");
    endtask

    task automatic t_sel_reg();
        logic [7:0] v;
        wr(A_SEL, 8'hFF);
        rd(A_SEL, v);
        chk(v == 8'h07, "R2", int'(v), 7);
        wr(A_SEL, 8'hFA);
        rd(A_SEL, v);
        chk(v == 8'h02, "R2", int'(v), 2);
        wr(A_SEL, 8'h00);
    endtask

    task automatic t_timeout(input int s);
        int n, h;
        wr(A_SEL, 8'(s));
        service();
        wait_rst(5000, n);
        chk(n == term(s), "R3", n, term(s));
        pulse_len(h);
        chk(h == PLEN, "R4", h, PLEN);
        run_quiet(3 * term(s), "R4");
        wr(A_SEL, 8'h00);
    endtask

    task automatic t_mcen();
        int n = 0, h;
        service();
        while (!wrst && n < 500) begin
            mc_en = ((n % 3) == 2);
            @(negedge clk);
            n++;
        end
        mc_en = 1'b1;
        chk(n == 3 * term(0), "R3", n, 3 * term(0));
        pulse_len(h);
    endtask

    task automatic t_badseq();
        wr(A_SVC, 8'hE1);
        run_quiet(4 * term(0), "R5");
        wr(A_SVC, 8'h1E);
        wr(A_SVC, 8'h55);
        wr(A_SVC, 8'hE1);
        run_quiet(4 * term(0), "R5");
    endtask

    task automatic t_restart();
        int n, h;
        service();
        for (int i = 0; i < 10; i++) @(negedge clk);
        service();
        wait_rst(500, n);
        chk(n == term(0), "R6", n, term(0));
        pulse_len(h);
    endtask

    task automatic t_idle();
        int n, h;
        idle = 1'b1;
        service();
        wait_rst(500, n);
        chk(n == term(0), "R7", n, term(0));
        pulse_len(h);
        idle = 1'b0;
    endtask

    task automatic t_pdown();
        int n, h;
        service();
        for (int i = 0; i < 5; i++) @(negedge clk);
        pdown = 1'b1;
        run_quiet(30, "R8");
        pdown = 1'b0;
        wait_rst(500, n);
        chk(n == term(0) - 5, "R8", n, term(0) - 5);
        pulse_len(h);
    endtask

    task automatic t_wake();
        int n, h;
        service();
        for (int i = 0; i < 5; i++) @(negedge clk);
        int_n = 1'b0;
        pdown = 1'b1;
        run_quiet(20, "R9");
        pdown = 1'b0;
        run_quiet(25, "R9");
        int_n = 1'b1;
        wait_rst(500, n);
        chk(n == term(0) - 5 + 1, "R9", n, term(0) - 4);
        pulse_len(h);
    endtask

    task automatic t_hwreset();
        logic [7:0] v;
        wr(A_SEL, 8'h03);
        service();
        for (int i = 0; i < 5; i++) @(negedge clk);
        pdown = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pdown = 1'b0;
        rd(A_SEL, v);
        chk(v == 8'h00, "R10", int'(v), 0);
        chk(wrst == 1'b0, "R10", int'(wrst), 0);
        run_quiet(3 * term(3), "R10");
    endtask

    task automatic t_selchange();
        int n, h;
        service();
        wr(A_SEL, 8'h01);
        wait_rst(500, n);
        chk(n + 1 == term(0), "R11", n + 1, term(0));
        pulse_len(h);
        service();
        wait_rst(500, n);
        chk(n == term(1), "R11", n, term(1));
        pulse_len(h);
        wr(A_SEL, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sel_reg();
        t_timeout(0);
        t_timeout(2);
        t_mcen();
        t_badseq();
        t_restart();
        t_idle();
        t_pdown();
        t_wake();
        t_hwreset();
        t_selchange();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule